// File: doc/BRIEF.md
# SDRAM Four-Bank Command State Tracker

This block sits on the device side of an SDRAM command bus. On every rising clock edge it samples the clock-enable input together with an already decoded command, a two-bit bank select and the address bus. From these it keeps a state for each of four independent banks, the row each bank has open, and a state for the device as a whole. It flags any command that the current state does not allow.

Each bank moves on its own between idle, row active, read or write bursts with or without automatic precharge, and precharge. Burst ends and precharge completion are timed by simple per-bank cycle counters. The burst length is taken from the mode register. The device-level machine covers mode register loading, auto refresh, self refresh with an exit delay, idle and active power down, and read and write clock suspend. While the device is in any of these non-running states, every bank holds its state and its counters.

Typical uses are as a protocol checker beside a memory controller, or as the state core of a memory model.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After synchronous reset, every bank reads idle (0), every open row reads 0, the device reads running (0), the illegal flag is low and the burst length is 4. Command codes are: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode load, 7 burst stop. Bank state codes are: 0 idle, 1 active, 2 read, 3 write, 4 read with auto-precharge, 5 write with auto-precharge, 6 precharging. Device codes are: 0 running, 1 mode load, 2 auto refresh, 3 self refresh, 4 self-refresh exit, 5 idle power down, 6 active power down, 7 read suspend, 8 write suspend.
- R2: While the device is running with clock enable high, an activate sent to an idle bank selected by `ba` makes that bank active and stores `addr` as its open row. Bank n occupies bits [3n+2:3n] of `bank_state_o` and bits [13n+12:13n] of `open_row_o`.
- R3: An activate sent to a bank that is not idle is illegal. It changes no bank state and no open row.
- R4: A read or write sent to an active, reading or writing bank starts a burst that lasts the burst length in cycles. With `addr[10]` low, the bank then returns to active. With `addr[10]` high, the bank uses the auto-precharge burst state and afterwards precharges for TRP cycles before it becomes idle.
- R5: A read or write sent to a bank that is idle, precharging or in an auto-precharge burst is illegal and changes no state.
- R6: A precharge with `addr[10]` high moves every active, reading or writing bank to precharging, whatever the value of `ba`. With `addr[10]` low it moves only the selected bank. Banks in any other state are not affected, and a precharge is never illegal.
- R7: Burst stop returns every bank in a plain read or write burst to active. It leaves auto-precharge bursts running.
- R8: When a read or write is accepted, a burst in any other bank ends. A plain burst returns to active, and an auto-precharge burst starts precharging.
- R9: A mode load with all banks idle sets the burst length from `addr[2:0]`: 0, 1, 2 and 3 give 1, 2, 4 and 8 cycles, and 7 gives a full-page burst that never ends by counting. The device then spends TMRD cycles in mode load. Codes 4 to 6, or any bank not idle, make the command illegal and leave the mode unchanged.
- R10: A refresh with clock enable high and all banks idle holds the device in auto refresh for TRFC cycles, after which it runs again with all banks idle. A refresh with any bank not idle is illegal.
- R11: Any command other than NOP received during mode load, auto refresh or self-refresh exit is illegal and is ignored.
- R12: A refresh received with clock enable low, while the device is running and all banks are idle, enters self refresh. The device stays there while clock enable is low. Once clock enable is high it passes TXSR cycles in self-refresh exit and then runs again.
- R13: In any other case, clock enable low while running enters write suspend (if a write burst is in progress), read suspend (if a read burst is in progress), active power down (if any bank is not idle), or idle power down (otherwise). Bank states and counters freeze, and commands are ignored. The first edge with clock enable high returns the device to running and ignores the command on that edge.
- R14: The illegal flag is registered. It is high for exactly the one cycle after the edge that received the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable sampled from the bus |
| cmd | input | 3 | Decoded command code |
| ba | input | BA_W (2) | Bank select |
| addr | input | ROW_W (13) | Row address; bit 10 selects all-bank or auto-precharge; bits 2:0 carry the mode code |
| bank_state_o | output | 3*NB (12) | Packed per-bank state codes |
| open_row_o | output | ROW_W*NB (52) | Packed per-bank open row |
| dev_state_o | output | 4 | Device state code |
| illegal_o | output | 1 | One-cycle illegal-command flag |

## Verification
The bench aims at the following corner cases:
- An activate to an open bank. A design that accepted it would overwrite the stored row.
- A read or write to an idle bank. A design that accepted it would start a burst with no row open.
- A command accepted to one bank while another bank is bursting. A design that kept banks fully separate would let two bursts run at once, or would never start precharge after an interrupted auto-precharge burst.
- Precharge-all with an unrelated bank select, and burst stop against an auto-precharge burst.
- Clock enable dropping in the middle of a burst, and commands sent during suspend. A design that kept counting or acted on those commands would show the burst ending early or banks changing while the clock is stopped.
- Self-refresh entry, the exit delay, and commands sent during the exit delay.
- Mode codes at the valid and reserved boundaries.

Long mixed random runs compare every output in every cycle.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6,
        CMD_BST = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE     = 3'd0,
        BK_ACTIVE   = 3'd1,
        BK_READ     = 3'd2,
        BK_WRITE    = 3'd3,
        BK_READ_AP  = 3'd4,
        BK_WRITE_AP = 3'd5,
        BK_PRECHG   = 3'd6
    } bank_st_e;

    typedef enum logic [3:0] {
        DV_RUN       = 4'd0,
        DV_MODESET   = 4'd1,
        DV_AREF      = 4'd2,
        DV_SREF      = 4'd3,
        DV_SREF_EXIT = 4'd4,
        DV_IDLE_PD   = 4'd5,
        DV_ACT_PD    = 4'd6,
        DV_RD_SUSP   = 4'd7,
        DV_WR_SUSP   = 4'd8
    } dev_st_e;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic auto_pre;
        logic pre;
        logic stop;
        logic intr;
    } bank_op_t;

    typedef struct packed {
        logic             full_page;
        logic [CNT_W-1:0] last;
    } burst_cfg_t;

    function automatic logic st_is_open(bank_st_e s);
        return (s == BK_ACTIVE) || (s == BK_READ) || (s == BK_WRITE);
    endfunction

    function automatic logic st_is_burst(bank_st_e s);
        return (s == BK_READ) || (s == BK_WRITE) || (s == BK_READ_AP) || (s == BK_WRITE_AP);
    endfunction

    function automatic logic st_is_wr(bank_st_e s);
        return (s == BK_WRITE) || (s == BK_WRITE_AP);
    endfunction

    function automatic logic mode_ok(logic [2:0] code);
        return (code <= 3'd3) || (code == 3'd7);
    endfunction

    function automatic burst_cfg_t mode_to_cfg(logic [2:0] code);
        burst_cfg_t c;
        c.full_page = (code == 3'd7);
        case (code)
            3'd0:    c.last = CNT_W'(0);
            3'd1:    c.last = CNT_W'(1);
            3'd2:    c.last = CNT_W'(3);
            3'd3:    c.last = CNT_W'(7);
            default: c.last = CNT_W'(0);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int TRP   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  bank_op_t         op,
    input  logic [ROW_W-1:0] row_in,
    input  burst_cfg_t       cfg,
    output bank_st_e         state,
    output logic [ROW_W-1:0] row
);

    localparam logic [CNT_W-1:0] TRP_LAST = CNT_W'(TRP - 1);

    logic [CNT_W-1:0] cnt, cnt_d;
    logic             fp, fp_d;
    bank_st_e         st_d;

    always_comb begin
        st_d  = state;
        cnt_d = cnt;
        fp_d  = fp;
        if (op.rd || op.wr) begin
            if (op.rd) st_d = op.auto_pre ? BK_READ_AP : BK_READ;
            else       st_d = op.auto_pre ? BK_WRITE_AP : BK_WRITE;
            cnt_d = cfg.last;
            fp_d  = cfg.full_page;
        end else if (op.act) begin
            st_d = BK_ACTIVE;
        end else if (op.pre && st_is_open(state)) begin
            st_d  = BK_PRECHG;
            cnt_d = TRP_LAST;
        end else if (op.stop && (state == BK_READ || state == BK_WRITE)) begin
            st_d = BK_ACTIVE;
        end else if (op.intr && st_is_burst(state)) begin
            if (state == BK_READ_AP || state == BK_WRITE_AP) begin
                st_d  = BK_PRECHG;
                cnt_d = TRP_LAST;
            end else begin
                st_d = BK_ACTIVE;
            end
        end else begin
            case (state)
                BK_READ, BK_WRITE, BK_READ_AP, BK_WRITE_AP: begin
                    if (!fp) begin
                        if (cnt == '0) begin
                            if (state == BK_READ || state == BK_WRITE) begin
                                st_d = BK_ACTIVE;
                            end else begin
                                st_d  = BK_PRECHG;
                                cnt_d = TRP_LAST;
                            end
                        end else begin
                            cnt_d = cnt - 1'b1;
                        end
                    end
                end
                BK_PRECHG: begin
                    if (cnt == '0) st_d = BK_IDLE;
                    else           cnt_d = cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BK_IDLE;
            cnt   <= '0;
            fp    <= 1'b0;
            row   <= '0;
        end else if (tick) begin
            state <= st_d;
            cnt   <= cnt_d;
            fp    <= fp_d;
            if (op.act) row <= row_in;
        end
    end

endmodule

// File: rtl/sdram_dev_ctrl.sv
module sdram_dev_ctrl
    import sdram_trk_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = 2,
    parameter int TMRD = 2,
    parameter int TRFC = 4,
    parameter int TXSR = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  cmd_e            cmd,
    input  logic [BA_W-1:0] ba,
    input  logic            ap_bit,
    input  logic [2:0]      mode_code,
    input  bank_st_e        bank_st [NB],
    output dev_st_e         dev_st,
    output logic            tick,
    output bank_op_t        ops [NB],
    output burst_cfg_t      cfg,
    output logic            illegal
);

    localparam logic [CNT_W-1:0] TMRD_LAST = CNT_W'(TMRD - 1);
    localparam logic [CNT_W-1:0] TRFC_LAST = CNT_W'(TRFC - 1);
    localparam logic [CNT_W-1:0] TXSR_LAST = CNT_W'(TXSR - 1);

    logic             all_idle, any_burst, any_wr;
    logic             cmd_ok;
    logic [2:0]       bl_code;
    logic [CNT_W-1:0] dcnt;
    bank_st_e         sel_st;

    assign sel_st = bank_st[ba];
    assign tick   = (dev_st == DV_RUN) && cke;
    assign cfg    = mode_to_cfg(bl_code);

    always_comb begin
        all_idle  = 1'b1;
        any_burst = 1'b0;
        any_wr    = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (bank_st[b] != BK_IDLE) all_idle = 1'b0;
            if (st_is_burst(bank_st[b])) any_burst = 1'b1;
            if (st_is_wr(bank_st[b]))    any_wr    = 1'b1;
        end
    end

    always_comb begin
        cmd_ok = 1'b1;
        for (int b = 0; b < NB; b++) ops[b] = '0;
        if (tick) begin
            case (cmd)
                CMD_ACT: begin
                    if (sel_st == BK_IDLE) ops[ba].act = 1'b1;
                    else                   cmd_ok = 1'b0;
                end
                CMD_RD, CMD_WR: begin
                    if (st_is_open(sel_st)) begin
                        for (int b = 0; b < NB; b++) begin
                            if (b == int'(ba)) begin
                                ops[b].rd       = (cmd == CMD_RD);
                                ops[b].wr       = (cmd == CMD_WR);
                                ops[b].auto_pre = ap_bit;
                            end else begin
                                ops[b].intr = 1'b1;
                            end
                        end
                    end else begin
                        cmd_ok = 1'b0;
                    end
                end
                CMD_PRE: begin
                    for (int b = 0; b < NB; b++) ops[b].pre = ap_bit || (b == int'(ba));
                end
                CMD_BST: begin
                    for (int b = 0; b < NB; b++) ops[b].stop = 1'b1;
                end
                CMD_REF: cmd_ok = all_idle;
                CMD_MRS: cmd_ok = all_idle && mode_ok(mode_code);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_st  <= DV_RUN;
            dcnt    <= '0;
            bl_code <= 3'd2;
            illegal <= 1'b0;
        end else begin
            illegal <= 1'b0;
            case (dev_st)
                DV_RUN: begin
                    if (!cke) begin
                        if (cmd == CMD_REF && all_idle) dev_st <= DV_SREF;
                        else if (any_burst)             dev_st <= any_wr ? DV_WR_SUSP : DV_RD_SUSP;
                        else if (all_idle)              dev_st <= DV_IDLE_PD;
                        else                            dev_st <= DV_ACT_PD;
                    end else begin
                        illegal <= !cmd_ok;
                        if (cmd_ok && cmd == CMD_REF) begin
                            dev_st <= DV_AREF;
                            dcnt   <= TRFC_LAST;
                        end else if (cmd_ok && cmd == CMD_MRS) begin
                            dev_st  <= DV_MODESET;
                            dcnt    <= TMRD_LAST;
                            bl_code <= mode_code;
                        end
                    end
                end
                DV_MODESET, DV_AREF, DV_SREF_EXIT: begin
                    illegal <= (cmd != CMD_NOP);
                    if (dcnt == '0) dev_st <= DV_RUN;
                    else            dcnt   <= dcnt - 1'b1;
                end
                DV_SREF: begin
                    if (cke) begin
                        dev_st <= DV_SREF_EXIT;
                        dcnt   <= TXSR_LAST;
                    end
                end
                default: begin
                    if (cke) dev_st <= DV_RUN;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 13,
    parameter int AP_BIT = 10,
    parameter int TRP    = 2,
    parameter int TMRD   = 2,
    parameter int TRFC   = 4,
    parameter int TXSR   = 3,
    localparam int NB    = 1 << BA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cke,
    input  logic [2:0]          cmd,
    input  logic [BA_W-1:0]     ba,
    input  logic [ROW_W-1:0]    addr,
    output logic [NB*3-1:0]     bank_state_o,
    output logic [NB*ROW_W-1:0] open_row_o,
    output logic [3:0]          dev_state_o,
    output logic                illegal_o
);

    cmd_e       cmd_c;
    bank_st_e   bank_st [NB];
    bank_op_t   ops     [NB];
    dev_st_e    dev_st;
    burst_cfg_t cfg;
    logic       tick;

    assign cmd_c = cmd_e'(cmd);

    sdram_dev_ctrl #(
        .NB(NB), .BA_W(BA_W), .TMRD(TMRD), .TRFC(TRFC), .TXSR(TXSR)
    ) ctrl_i (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd_c), .ba(ba),
        .ap_bit(addr[AP_BIT]), .mode_code(addr[2:0]), .bank_st(bank_st),
        .dev_st(dev_st), .tick(tick), .ops(ops), .cfg(cfg), .illegal(illegal_o)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic [ROW_W-1:0] row_q;
        sdram_bank_fsm #(.ROW_W(ROW_W), .TRP(TRP)) bank_i (
            .clk(clk), .rst(rst), .tick(tick), .op(ops[g]), .row_in(addr),
            .cfg(cfg), .state(bank_st[g]), .row(row_q)
        );
        assign bank_state_o[g*3 +: 3]         = bank_st[g];
        assign open_row_o[g*ROW_W +: ROW_W]   = row_q;
    end

    assign dev_state_o = dev_st;

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
    import sdram_trk_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13,
    localparam int NB   = 1 << BA_W
) (
    input logic                clk,
    input logic                rst,
    input logic                cke,
    input logic [2:0]          cmd,
    input logic [BA_W-1:0]     ba,
    input logic                a10,
    input logic [NB*3-1:0]     bank_state_o,
    input logic [NB*ROW_W-1:0] open_row_o,
    input logic [3:0]          dev_state_o,
    input logic                illegal_o
);

    logic            run;
    logic [2:0]      sel_st;
    logic [BA_W-1:0] ba_q;
    logic            lowpow;
    logic            dev_busy;

    assign run      = (dev_state_o == DV_RUN) && cke;
    assign sel_st   = bank_state_o[int'(ba)*3 +: 3];
    assign lowpow   = (dev_state_o == DV_SREF) || (dev_state_o == DV_IDLE_PD) ||
                      (dev_state_o == DV_ACT_PD) || (dev_state_o == DV_RD_SUSP) ||
                      (dev_state_o == DV_WR_SUSP);
    assign dev_busy = (dev_state_o == DV_MODESET) || (dev_state_o == DV_AREF) ||
                      (dev_state_o == DV_SREF_EXIT);

    always_ff @(posedge clk) ba_q <= ba;

    function automatic logic none_open(logic [NB*3-1:0] v);
        logic r;
        r = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (v[i*3 +: 3] == BK_ACTIVE || v[i*3 +: 3] == BK_READ || v[i*3 +: 3] == BK_WRITE)
                r = 1'b0;
        end
        return r;
    endfunction

    // R2
    act_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cmd == CMD_ACT && sel_st == BK_IDLE) |=> (bank_state_o[int'(ba_q)*3 +: 3] == BK_ACTIVE));

    // R3
    act_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cmd == CMD_ACT && sel_st != BK_IDLE) |=> (illegal_o && $stable(open_row_o)));

    // R6
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cmd == CMD_PRE && a10) |=> none_open(bank_state_o));

    // R11
    busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_busy && cmd != CMD_NOP) |=> illegal_o);

    // R12
    sref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_state_o == DV_SREF && !cke) |=> (dev_state_o == DV_SREF));

    // R13
    lp_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        lowpow |=> $stable(bank_state_o));

    // R14
    illegal_src_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> ($past(cmd) != CMD_NOP));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.BA_W(BA_W), .ROW_W(ROW_W)) chk_i (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .ba(ba), .a10(addr[AP_BIT]),
    .bank_state_o(bank_state_o), .open_row_o(open_row_o),
    .dev_state_o(dev_state_o), .illegal_o(illegal_o)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb_top;
    import sdram_trk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TRP = 2, TMRD = 2, TRFC = 4, TXSR = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        cke;
    logic [2:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [11:0] bank_state_o;
    logic [51:0] open_row_o;
    logic [3:0]  dev_state_o;
    logic        illegal_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [2:0]  m_st  [4];
    logic [12:0] m_row [4];
    int          m_cnt [4];
    bit          m_fp  [4];
    logic [3:0]  m_dev;
    int          m_dcnt;
    logic [2:0]  m_bl;
    bit          m_ill;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_tracker dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .ba(ba), .addr(addr),
        .bank_state_o(bank_state_o), .open_row_o(open_row_o),
        .dev_state_o(dev_state_o), .illegal_o(illegal_o)
    );

    function automatic int bl_last(logic [2:0] c);
        case (c)
            3'd1: return 1;
            3'd2: return 3;
            3'd3: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_burst(logic [2:0] s);
        return s >= 3'd2 && s <= 3'd5;
    endfunction

    function automatic bit is_open(logic [2:0] s);
        return s >= 3'd1 && s <= 3'd3;
    endfunction

    task automatic timer(int i);
        if (is_burst(m_st[i])) begin
            if (!m_fp[i]) begin
                if (m_cnt[i] == 0) begin
                    if (m_st[i] <= 3'd3) m_st[i] = BK_ACTIVE;
                    else begin m_st[i] = BK_PRECHG; m_cnt[i] = TRP - 1; end
                end else m_cnt[i]--;
            end
        end else if (m_st[i] == BK_PRECHG) begin
            if (m_cnt[i] == 0) m_st[i] = BK_IDLE;
            else m_cnt[i]--;
        end
    endtask

    task automatic model(bit k, logic [2:0] c, logic [1:0] b, logic [12:0] a);
        logic [2:0] o [4];
        bit allid = 1, anyb = 0, anyw = 0, ok = 1, done;
        for (int i = 0; i < 4; i++) begin
            o[i] = m_st[i];
            if (o[i] != BK_IDLE) allid = 0;
            if (is_burst(o[i])) anyb = 1;
            if (o[i] == BK_WRITE || o[i] == BK_WRITE_AP) anyw = 1;
        end
        m_ill = 0;
        case (m_dev)
            DV_RUN: begin
                if (!k) begin
                    if (c == CMD_REF && allid) m_dev = DV_SREF;
                    else if (anyb) m_dev = anyw ? DV_WR_SUSP : DV_RD_SUSP;
                    else if (allid) m_dev = DV_IDLE_PD;
                    else m_dev = DV_ACT_PD;
                end else begin
                    case (c)
                        CMD_ACT: ok = (o[b] == BK_IDLE);
                        CMD_RD, CMD_WR: ok = is_open(o[b]);
                        CMD_REF: ok = allid;
                        CMD_MRS: ok = allid && (a[2:0] <= 3'd3 || a[2:0] == 3'd7);
                        default: ok = 1;
                    endcase
                    m_ill = !ok;
                    for (int i = 0; i < 4; i++) begin
                        done = 0;
                        if (ok) begin
                            case (c)
                                CMD_ACT: if (i == b) begin m_st[i] = BK_ACTIVE; m_row[i] = a; done = 1; end
                                CMD_RD, CMD_WR: begin
                                    if (i == b) begin
                                        m_st[i] = (c == CMD_RD) ? (a[10] ? BK_READ_AP : BK_READ)
                                                                : (a[10] ? BK_WRITE_AP : BK_WRITE);
                                        m_cnt[i] = bl_last(m_bl);
                                        m_fp[i] = (m_bl == 3'd7);
                                        done = 1;
                                    end else if (is_burst(o[i])) begin
                                        if (o[i] >= 3'd4) begin m_st[i] = BK_PRECHG; m_cnt[i] = TRP - 1; end
                                        else m_st[i] = BK_ACTIVE;
                                        done = 1;
                                    end
                                end
                                CMD_PRE: if ((a[10] || i == b) && is_open(o[i])) begin
                                    m_st[i] = BK_PRECHG; m_cnt[i] = TRP - 1; done = 1;
                                end
                                CMD_BST: if (o[i] == BK_READ || o[i] == BK_WRITE) begin
                                    m_st[i] = BK_ACTIVE; done = 1;
                                end
                                default: ;
                            endcase
                        end
                        if (!done) timer(i);
                    end
                    if (ok && c == CMD_REF) begin m_dev = DV_AREF; m_dcnt = TRFC - 1; end
                    if (ok && c == CMD_MRS) begin m_dev = DV_MODESET; m_dcnt = TMRD - 1; m_bl = a[2:0]; end
                end
            end
            DV_MODESET, DV_AREF, DV_SREF_EXIT: begin
                m_ill = (c != CMD_NOP);
                if (m_dcnt == 0) m_dev = DV_RUN; else m_dcnt--;
            end
            DV_SREF: if (k) begin m_dev = DV_SREF_EXIT; m_dcnt = TXSR - 1; end
            default: if (k) m_dev = DV_RUN;
        endcase
    endtask

    task automatic compare(string tag);
        logic [11:0] es;
        logic [51:0] er;
        for (int i = 0; i < 4; i++) begin
            es[i*3 +: 3] = m_st[i];
            er[i*13 +: 13] = m_row[i];
        end
        n_chk++;
        if (bank_state_o !== es || open_row_o !== er || dev_state_o !== m_dev || illegal_o !== m_ill) begin
            n_bad++;
            $display("FAIL %s: act st=%h row=%h dev=%0d ill=%b exp st=%h row=%h dev=%0d ill=%b",
                     tag, bank_state_o, open_row_o, dev_state_o, illegal_o, es, er, m_dev, m_ill);
        end
    endtask

    task automatic lit(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(bit k, logic [2:0] c, logic [1:0] b, logic [12:0] a, string tag);
        @(negedge clk);
        cke = k; cmd = c; ba = b; addr = a;
        model(k, c, b, a);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic idle_n(int n, string tag);
        for (int i = 0; i < n; i++) step(1, CMD_NOP, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; cke = 1; cmd = 0; ba = 0; addr = 0;
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_row[i] = 0; m_cnt[i] = 0; m_fp[i] = 0; end
        m_dev = DV_RUN; m_dcnt = 0; m_bl = 3'd2; m_ill = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        lit("R1", {bank_state_o, dev_state_o, illegal_o}, 64'd0);
        lit("R1 rows", open_row_o, 64'd0);

        step(1, CMD_ACT, 2, 13'h155, "R2");
        lit("R2 state", bank_state_o[8:6], 64'd1);
        lit("R2 row", open_row_o[38:26], 64'h155);
        step(1, CMD_ACT, 2, 13'h0AA, "R3");
        lit("R3 flag", illegal_o, 64'd1);
        lit("R3 row", open_row_o[38:26], 64'h155);
        step(1, CMD_NOP, 0, 0, "R14");
        lit("R14 drop", illegal_o, 64'd0);
        step(1, CMD_RD, 0, 0, "R5");
        step(1, CMD_RD, 2, 0, "R4");
        idle_n(4, "R4");
        lit("R4 back", bank_state_o[8:6], 64'd1);
        step(1, CMD_ACT, 1, 13'h033, "R2");
        step(1, CMD_RD, 1, 13'h400, "R4");
        step(1, CMD_RD, 1, 13'h000, "R5");
        step(1, CMD_WR, 2, 0, "R8");
        lit("R8 intr", bank_state_o[5:3], 64'd6);
        idle_n(4, "R8");
        step(1, CMD_RD, 2, 0, "R7");
        step(1, CMD_BST, 3, 0, "R7");
        step(1, CMD_ACT, 0, 13'h1FF, "R2");
        step(1, CMD_WR, 0, 13'h400, "R7");
        step(1, CMD_BST, 0, 0, "R7");
        idle_n(6, "R4");
        step(1, CMD_ACT, 3, 13'h077, "R2");
        step(1, CMD_PRE, 1, 13'h000, "R6");
        step(1, CMD_PRE, 3, 13'h000, "R6");
        step(1, CMD_PRE, 1, 13'h400, "R6");
        idle_n(3, "R6");
        step(1, CMD_MRS, 0, 13'h005, "R9");
        step(1, CMD_MRS, 0, 13'h001, "R9");
        step(1, CMD_ACT, 0, 13'h010, "R11");
        idle_n(2, "R9");
        step(1, CMD_ACT, 0, 13'h010, "R2");
        step(1, CMD_RD, 0, 0, "R9");
        idle_n(3, "R9");
        step(1, CMD_REF, 0, 0, "R10");
        step(1, CMD_PRE, 0, 13'h400, "R6");
        idle_n(2, "R6");
        step(1, CMD_REF, 0, 0, "R10");
        step(1, CMD_REF, 0, 0, "R11");
        idle_n(4, "R10");
        step(0, CMD_REF, 0, 0, "R12");
        lit("R12 sref", dev_state_o, 64'd3);
        step(0, CMD_ACT, 1, 0, "R12");
        step(1, CMD_NOP, 0, 0, "R12");
        step(1, CMD_ACT, 1, 0, "R11");
        idle_n(3, "R12");
        step(1, CMD_ACT, 0, 13'h002, "R2");
        step(1, CMD_WR, 0, 0, "R13");
        step(0, CMD_NOP, 0, 0, "R13");
        lit("R13 wsusp", dev_state_o, 64'd8);
        step(0, CMD_BST, 0, 0, "R13");
        step(1, CMD_PRE, 0, 13'h400, "R13");
        idle_n(3, "R13");
        step(0, CMD_NOP, 0, 0, "R13");
        step(1, CMD_NOP, 0, 0, "R13");
        step(1, CMD_MRS, 0, 13'h007, "R9");
        idle_n(2, "R9");

        for (int n = 0; n < 6000; n++) begin
            int r;
            bit k;
            logic [2:0] c;
            logic [12:0] a;
            r = $urandom % 100;
            k = ($urandom % 100) >= 6;
            if (r < 28) c = CMD_NOP;
            else if (r < 46) c = CMD_ACT;
            else if (r < 58) c = CMD_RD;
            else if (r < 70) c = CMD_WR;
            else if (r < 82) c = CMD_PRE;
            else if (r < 88) c = CMD_BST;
            else if (r < 94) c = CMD_REF;
            else c = CMD_MRS;
            a = 13'($urandom);
            if (c == CMD_MRS && a[2:0] == 3'd7 && ($urandom % 4) != 0) a[2:0] = 3'd3;
            step(k, c, 2'($urandom), a, "R8 mixed");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule